// File: doc/BRIEF.md
# Scan-Chain Register Access Port for a Trace Buffer

This block is a debug data register behind a test access port. A debugger uses it to read and write a small bank of 32-bit registers that control an on-chip trace buffer. Each scan moves one 40-bit word. The word holds a data field, a register address and a direction bit. A write lands in the addressed register at the update phase. A read is pipelined: the address sent in one scan picks the register whose value comes back in the data field of the next scan.

The identification, RAM depth and RAM width words are parameter constants inside the block. The RAM read pointer is also held inside the block. Status, RAM data, write pointer, trigger counter and control sit outside the block. They are reached over a simple register bus clocked by the test clock. A read strobe fires in the Capture-DR cycle. A write strobe fires in the Update-DR cycle. Every bus access to the RAM data address moves the read pointer forward, so repeated reads stream out RAM contents. A closing read of the identification address ends a stream without using up another RAM word.

The TAP controller is outside the block. Its current state and the instruction register value arrive as inputs. A 5-bit chain-select register decides whether the register-access scan is connected at all.

Top module: `trace_reg_scan`

## Requirements
- R1: TAP state codes are Capture-DR 4'h6, Shift-DR 4'h2 and Update-DR 4'h5. Instruction 4'h2 selects the chain-select register and instruction 4'hC selects register access. The register-access word is 40 bits, shifted in on `tdi` and out on `tdo` least significant bit first. Bits 31:0 are data, bits 38:32 are the address, and bit 39 is the direction (1 = write, 0 = read).
- R2: The chain-select register is 5 bits wide and resets to 5'h1F. Capture loads its current value into the shift path, and Update-DR under instruction 4'h2 loads the shifted value. Register access is live only while chain 0 is selected. Otherwise instruction 4'hC, like every other instruction, gives a one-bit bypass path that captures 0, with no strobes and no register change.
- R3: A read is pipelined. The data field captured in a scan holds the value of the address read in the previous register-access scan, and bits 39:32 capture as zero. After reset the first scan returns the identification word.
- R4: Addresses 0, 1 and 2 read back `ID_VALUE`, `RAM_DEPTH` and `RAM_WIDTH`. Writes to them change nothing and issue no bus write.
- R5: Address 5 is the RAM read pointer, held in the block and driven on `ram_ptr`. A write loads the low pointer bits of the data field at Update-DR, and a read returns the pointer zero-extended. The pointer changes for no other reason than R5, R6 and R7.
- R6: A read of address 4 issues `bus_rd` with `bus_addr` = 4 in the next scan's Capture-DR cycle and captures `bus_rdata`. The read pointer then advances by one, wrapping from `RAM_DEPTH`-1 to 0. A following read of address 0 leaves the pointer unchanged.
- R7: A write of address 4 issues `bus_wr` at Update-DR with `bus_addr` = 4, `bus_wdata` equal to the data field, and `ram_ptr` naming the RAM word. The pointer then advances with the same wrap as in R6.
- R8: Addresses 3, 6, 7 and 8 are external. A read issues `bus_rd` at the following Capture-DR and returns `bus_rdata`. A write issues `bus_wr` at Update-DR with `bus_wdata` equal to the data field.
- R9: Addresses 9 to 127 read as zero. Writes to them are dropped, and no strobe names them.
- R10: The scan that follows a write captures zero in all 40 bits and issues no `bus_rd`.
- R11: `bus_rd` and `bus_wr` never assert together. Each is high only in its own TAP state under instruction 4'hC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tap_state | input | 4 | Current TAP controller state code |
| ir | input | 4 | Current instruction register value |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out from the selected path |
| bus_addr | output | 7 | Register address of the current strobe |
| bus_rd | output | 1 | One-cycle read strobe at Capture-DR |
| bus_wr | output | 1 | One-cycle write strobe at Update-DR |
| bus_wdata | output | 32 | Write data (data field of the shifted word) |
| bus_rdata | input | 32 | Read data returned in the strobe cycle |
| ram_ptr | output | log2(RAM_DEPTH) (4) | RAM read pointer |

## Verification
The bench runs a full sweep that reads every address from 0 to 127. Each expected word is computed from the address read in the scan before it. This separates the constants, the in-block pointer, the external registers and the unmapped range, and it shows the one-scan pipeline lag. RAM streams start near the top of the RAM so that the pointer has to wrap. Single writes to constant and unmapped addresses show that nothing moves. Scans made while the chain is deselected, or under a foreign instruction, must come back as a one-bit-shifted copy of the input with no strobes. This separates the bypass path from the register path.

// File: rtl/trace_reg_scan.sv
module trace_reg_scan #(
  parameter logic [31:0] ID_VALUE  = 32'h5E3C_0A91,
  parameter int          RAM_DEPTH = 16,
  parameter int          RAM_WIDTH = 32,
  parameter int          CHAIN_W   = 5,
  parameter int          IR_W      = 4,
  parameter int          ADDR_W    = 7,
  parameter int          DATA_W    = 32,
  localparam int         PTR_W     = $clog2(RAM_DEPTH)
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic [3:0]        tap_state,
  input  logic [IR_W-1:0]   ir,
  input  logic              tdi,
  output logic              tdo,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [PTR_W-1:0]  ram_ptr
);
  localparam int SR_W = DATA_W + ADDR_W + 1;
  localparam logic [3:0] ST_CAPTURE = 4'h6;
  localparam logic [3:0] ST_SHIFT   = 4'h2;
  localparam logic [3:0] ST_UPDATE  = 4'h5;
  localparam logic [IR_W-1:0] IR_CHAIN = IR_W'(2);
  localparam logic [IR_W-1:0] IR_REGS  = IR_W'(12);
  localparam logic [ADDR_W-1:0] A_ID = 0, A_DEPTH = 1, A_WIDTH = 2, A_STATUS = 3, A_RAM = 4,
                                A_RPTR = 5, A_WPTR = 6, A_TRIG = 7, A_CTRL = 8;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(RAM_DEPTH - 1);

  logic [SR_W-1:0]    sr;
  logic [CHAIN_W-1:0] chain_sr, chain_sel;
  logic               byp;
  logic [ADDR_W-1:0]  pend_addr;
  logic               pend_rd;
  logic [DATA_W-1:0]  read_word;

  function automatic logic on_bus(input logic [ADDR_W-1:0] a);
    return (a == A_STATUS) || (a == A_RAM) || (a == A_WPTR) || (a == A_TRIG) || (a == A_CTRL);
  endfunction

  wire capture   = tap_state == ST_CAPTURE;
  wire shift     = tap_state == ST_SHIFT;
  wire update    = tap_state == ST_UPDATE;
  wire chain_dr  = ir == IR_CHAIN;
  wire regs_dr   = (ir == IR_REGS) && (chain_sel == '0);
  wire bypass_dr = !chain_dr && !regs_dr;

  wire [ADDR_W-1:0] upd_addr  = sr[DATA_W +: ADDR_W];
  wire              upd_write = sr[SR_W-1];

  assign bus_rd    = regs_dr && capture && pend_rd && on_bus(pend_addr);
  assign bus_wr    = regs_dr && update && upd_write && on_bus(upd_addr);
  assign bus_addr  = capture ? pend_addr : upd_addr;
  assign bus_wdata = sr[DATA_W-1:0];

  wire ram_hit   = (bus_rd || bus_wr) && (bus_addr == A_RAM);
  wire rptr_load = regs_dr && update && upd_write && (upd_addr == A_RPTR);

  always_comb begin
    read_word = '0;
    if (pend_rd) begin
      case (pend_addr)
        A_ID:    read_word = ID_VALUE;
        A_DEPTH: read_word = DATA_W'(RAM_DEPTH);
        A_WIDTH: read_word = DATA_W'(RAM_WIDTH);
        A_RPTR:  read_word = DATA_W'(ram_ptr);
        default: read_word = on_bus(pend_addr) ? bus_rdata : '0;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= '0;
    end else if (regs_dr) begin
      if (capture)    sr <= {{(ADDR_W + 1){1'b0}}, read_word};
      else if (shift) sr <= {tdi, sr[SR_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      chain_sr  <= '1;
      chain_sel <= '1;
    end else if (chain_dr) begin
      if (capture)     chain_sr  <= chain_sel;
      else if (shift)  chain_sr  <= {tdi, chain_sr[CHAIN_W-1:1]};
      else if (update) chain_sel <= chain_sr;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        byp <= 1'b0;
    else if (bypass_dr) begin
      if (capture)      byp <= 1'b0;
      else if (shift)   byp <= tdi;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      pend_addr <= A_ID;
      pend_rd   <= 1'b1;
    end else if (regs_dr && update) begin
      pend_addr <= upd_addr;
      pend_rd   <= !upd_write;
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)        ram_ptr <= '0;
    else if (rptr_load) ram_ptr <= bus_wdata[PTR_W-1:0];
    else if (ram_hit)   ram_ptr <= (ram_ptr == PTR_LAST) ? '0 : ram_ptr + 1'b1;
  end

  assign tdo = chain_dr ? chain_sr[0] : (regs_dr ? sr[0] : byp);
endmodule

// File: rtl/trace_reg_scan_chk.sv
module trace_reg_scan_chk #(
  parameter int RAM_DEPTH = 16,
  localparam int PTR_W = $clog2(RAM_DEPTH)
) (
  input logic             tck,
  input logic             trst_n,
  input logic [3:0]       tap_state,
  input logic [3:0]       ir,
  input logic [6:0]       bus_addr,
  input logic             bus_rd,
  input logic             bus_wr,
  input logic [PTR_W-1:0] ram_ptr
);
  p_excl_r11: assert property (@(posedge tck) disable iff (!trst_n) !(bus_rd && bus_wr));

  p_rd_state_r11: assert property (@(posedge tck) disable iff (!trst_n)
    bus_rd |-> (tap_state == 4'h6 && ir == 4'hC));

  p_wr_state_r11: assert property (@(posedge tck) disable iff (!trst_n)
    bus_wr |-> (tap_state == 4'h5 && ir == 4'hC));

  p_bus_range_r9: assert property (@(posedge tck) disable iff (!trst_n)
    (bus_rd || bus_wr) |-> (bus_addr == 7'd3 || bus_addr == 7'd4 || bus_addr == 7'd6 ||
                            bus_addr == 7'd7 || bus_addr == 7'd8));

  p_ptr_adv_r6: assert property (@(posedge tck) disable iff (!trst_n)
    ((bus_rd || bus_wr) && bus_addr == 7'd4) |=>
      ram_ptr == (($past(ram_ptr) == PTR_W'(RAM_DEPTH - 1)) ? '0 : PTR_W'($past(ram_ptr) + 1'b1)));

  p_ptr_hold_r5: assert property (@(posedge tck) disable iff (!trst_n)
    (tap_state != 4'h5 && !((bus_rd || bus_wr) && bus_addr == 7'd4)) |=> $stable(ram_ptr));
endmodule

bind trace_reg_scan trace_reg_scan_chk #(.RAM_DEPTH(RAM_DEPTH)) u_chk (
  .tck(tck), .trst_n(trst_n), .tap_state(tap_state), .ir(ir),
  .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .ram_ptr(ram_ptr));

// File: tb/trace_reg_scan_bench.sv
module trace_reg_scan_bench;
  localparam logic [31:0] ID = 32'h5E3C_0A91;
  localparam int DEPTH = 16;

  logic tck = 0, trst_n = 0, tdi = 0;
  logic [3:0] tap_state = 4'hC, ir = 4'hC;
  logic tdo, bus_rd, bus_wr;
  logic [6:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0] ram_ptr;

  logic [31:0] ram [DEPTH];
  logic [31:0] bank [16];
  int rd_cnt = 0, wr_cnt = 0, errors = 0, checks = 0, ptr_m = 0;

  always #4 tck = ~tck;

  trace_reg_scan #(.ID_VALUE(ID), .RAM_DEPTH(DEPTH)) u_trace_reg_scan (
    .tck(tck), .trst_n(trst_n), .tap_state(tap_state), .ir(ir), .tdi(tdi), .tdo(tdo),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .ram_ptr(ram_ptr));

  assign bus_rdata = (bus_addr == 7'd4) ? ram[ram_ptr] : bank[bus_addr[3:0]];

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      for (int i = 0; i < DEPTH; i++) ram[i] <= '0;
      for (int i = 0; i < 16; i++) bank[i] <= '0;
    end else begin
      if (bus_rd) rd_cnt++;
      if (bus_wr) begin
        wr_cnt++;
        if (bus_addr == 7'd4) ram[ram_ptr] <= bus_wdata;
        else bank[bus_addr[3:0]] <= bus_wdata;
      end
    end
  end

  function automatic logic [31:0] ram_val(input int i);
    return 32'hA500_0000 + i * 32'h0001_0203;
  endfunction

  function automatic logic [31:0] ext_val(input int a);
    return 32'hC0DE_0000 + a;
  endfunction

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic dr_scan(input int n, input logic [39:0] din, output logic [39:0] dout);
    dout = '0;
    @(negedge tck) tap_state = 4'h6;
    @(negedge tck) tap_state = 4'h2;
    for (int i = 0; i < n; i++) begin
      tdi = din[i];
      #1 dout[i] = tdo;
      @(negedge tck);
    end
    tap_state = 4'h5;
    @(negedge tck) tap_state = 4'hC;
  endtask

  task automatic acc(input logic wr, input int a, input logic [31:0] d, output logic [39:0] got);
    dr_scan(40, {wr, 7'(a), d}, got);
  endtask

  function automatic logic [31:0] exp_read(input int a);
    case (a)
      0: return ID;
      1: return 32'(DEPTH);
      2: return 32'd32;
      3, 6, 7, 8: return ext_val(a);
      4: return ram_val(ptr_m);
      5: return 32'(ptr_m);
      default: return 32'd0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge tck);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [39:0] got;
    int rc, wc, prev;
    repeat (3) @(negedge tck);
    trst_n = 1;
    @(negedge tck);
    chk("R1 reset ptr", 40'(ram_ptr), 40'd0);
    chk("R1 reset strobes", {38'd0, bus_rd, bus_wr}, 40'd0);

    // R2: chain deselected -> bypass under 4'hC
    rc = rd_cnt; wc = wr_cnt;
    dr_scan(40, 40'h93_1234_5678, got);
    chk("R2 bypass when deselected", got, {40'h93_1234_5678 << 1});
    chk("R2 no strobes when deselected", 40'(rd_cnt - rc + wr_cnt - wc), 40'd0);
    ir = 4'h2;
    dr_scan(5, 40'h0, got);
    chk("R2 chain reset value", got, 40'h1F);
    dr_scan(5, 40'h0, got);
    chk("R2 chain loaded", got, 40'h0);
    ir = 4'hC;

    // R3: first scan returns ID, pipeline of constants (R4)
    acc(0, 1, 0, got);  chk("R3 first scan id", got, {8'h0, ID});
    acc(0, 2, 0, got);  chk("R4 depth", got, 40'(DEPTH));
    acc(0, 0, 0, got);  chk("R4 width", got, 40'd32);
    wc = wr_cnt;
    acc(1, 1, 32'h7777, got); chk("R3 id via pipeline", got, {8'h0, ID});
    acc(0, 1, 0, got);  chk("R10 after write zero", got, 40'd0);
    acc(0, 0, 0, got);  chk("R4 depth unchanged by write", got, 40'(DEPTH));
    chk("R4 no bus write", 40'(wr_cnt - wc), 40'd0);

    // R5 / R7: fill RAM from pointer 14 with wrap
    acc(1, 5, 14, got);
    chk("R5 pointer loaded", 40'(ram_ptr), 40'd14);
    for (int i = 0; i < DEPTH; i++) begin
      acc(1, 4, ram_val((14 + i) % DEPTH), got);
      chk("R7 pointer advance", 40'(ram_ptr), 40'((15 + i) % DEPTH));
    end
    chk("R7 ram word 15", 40'(ram[15]), 40'(ram_val(15)));
    chk("R7 ram word 0 after wrap", 40'(ram[0]), 40'(ram_val(0)));

    // R6: streaming reads from 14
    acc(1, 5, 14, got);
    rc = rd_cnt;
    acc(0, 4, 0, got);  chk("R10 zero after write", got, 40'd0);
    chk("R6 no strobe before next scan", 40'(rd_cnt - rc), 40'd0);
    acc(0, 4, 0, got);  chk("R6 stream word 14", got, 40'(ram_val(14)));
    acc(0, 4, 0, got);  chk("R6 stream word 15", got, 40'(ram_val(15)));
    acc(0, 0, 0, got);  chk("R6 stream word 0 after wrap", got, 40'(ram_val(0)));
    chk("R6 pointer after stream", 40'(ram_ptr), 40'd1);
    acc(0, 0, 0, got);  chk("R6 closing read id", got, {8'h0, ID});
    chk("R6 closing read keeps pointer", 40'(ram_ptr), 40'd1);
    chk("R6 read strobe count", 40'(rd_cnt - rc), 40'd3);

    // R8: external registers
    for (int a = 3; a <= 8; a++)
      if (a != 4 && a != 5) begin
        acc(1, a, ext_val(a), got);
        chk("R8 bus write data", 40'(bank[a]), 40'(ext_val(a)));
      end

    // R9: unmapped writes dropped
    wc = wr_cnt;
    acc(1, 9, 32'hFFFF_FFFF, got);
    acc(1, 127, 32'h1234_5678, got);
    chk("R9 unmapped writes dropped", 40'(wr_cnt - wc), 40'd0);

    // R11: foreign instruction acts as bypass, pointer and strobes untouched
    ir = 4'h1; rc = rd_cnt; wc = wr_cnt;
    dr_scan(40, 40'h0F_0000_8001, got);
    chk("R11 foreign ir bypass", got, {40'h0F_0000_8001 << 1});
    chk("R11 foreign ir no strobes", 40'(rd_cnt - rc + wr_cnt - wc), 40'd0);
    chk("R11 foreign ir pointer kept", 40'(ram_ptr), 40'd1);
    ir = 4'hC;

    // sweep of all addresses
    acc(1, 5, 7, got);
    ptr_m = 7;
    prev = -1;
    for (int a = 0; a <= 128; a++) begin
      logic [39:0] e;
      string tag;
      e = (prev < 0) ? 40'd0 : {8'h0, exp_read(prev)};
      tag = (prev < 0) ? "R10 sweep start" : (prev <= 2) ? "R4 sweep" : (prev == 4) ? "R6 sweep" :
            (prev == 5) ? "R5 sweep" : (prev >= 9) ? "R9 sweep" : "R8 sweep";
      acc(0, a % 128, 0, got);
      chk(tag, got, e);
      if (prev == 4) ptr_m = (ptr_m + 1) % DEPTH;
      prev = a % 128;
    end
    chk("R6 sweep pointer", 40'(ram_ptr), 40'(ptr_m));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule